// File: doc/BRIEF.md
# Update-coalescing cache bank

This bank is a small two-way set-associative cache that takes two kinds of traffic: ordinary word reads, and commutative update commands that carry a word address, a reduction opcode and an operand. A line can hold real memory data or a set of partial results. Partial-result lines are marked by a per-line flag. An update that misses does not go to memory. It claims a line, fills every word with the identity of its opcode and folds the operand into the addressed word. Later updates to that line are folded into place by a reduction unit inside the bank.

A third command, merge, takes a whole line of partial results pushed up by a lower-level bank. It folds that line word by word into the matching partial-result line, or claims a new line for it when there is no match. When a line leaves the bank, an eviction port emits its line address, its data, the partial-result flag and its opcode. Partial-result lines and modified data lines are emitted this way. Clean data lines leave silently. Read misses fetch a whole line through a simple fill handshake, and the bank stalls its request side until the fill arrives.

Top module: `upd_coalesce_bank`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid`, `ev_valid` and `fill_req` are 0, and every line is invalid.
- R2: An update that misses claims a line and raises no `fill_req`. Opcodes are ADD=0, AND=1, OR=2, XOR=3. The identity is all-ones for AND and zero for the others. The addressed word becomes identity folded with the operand, and the other words hold the identity. `resp_valid` is high in the cycle after acceptance, and `resp_data` carries the new word value.
- R3: An update that hits a partial-result line with the same opcode folds the operand into the stored word: ADD modulo 2^64, or bitwise AND, OR or XOR. `resp_data` returns the folded value.
- R4: An update or merge whose opcode differs from that of the partial-result line it hits answers with `resp_err`=1 and `resp_data`=0. The line keeps its contents and its recency.
- R5: A read that hits a data line returns the word in the next cycle. A read that hits a partial-result line answers with `resp_err`=1 and `resp_data`=0, and raises no fill.
- R6: A read miss raises `fill_req` for one cycle, one cycle after acceptance, with `fill_addr` = word address >> 3. The response follows one cycle after `fill_valid` and carries the addressed word of `fill_data`. The line is installed as clean data.
- R7: A merge (command code 2) with `req_line` folds all eight words into a hitting partial-result line. When it misses, it claims a partial-result line that holds `req_line` unchanged. `resp_data` is the resulting word at the request address.
- R8: Address bits [2:0] pick the word, bits [4:3] the set, and the bits above form the tag. Allocation prefers an invalid way, and otherwise takes the least recently used way. Accepted hits and allocations make a way most recent.
- R9: Evicting a partial-result line pulses `ev_valid` with `ev_addr` = line address, the full line, `ev_buffered`=1 and `ev_op`. The pulse comes in the cycle of the response, or in the cycle of `fill_req` for a read miss.
- R10: Evicting a data line that an update or merge modified emits `ev_buffered`=0 with the modified data. Evicting a clean data line emits nothing.
- R11: An update that hits a data line applies its own opcode to the stored word, whatever that opcode is, and marks the line modified. The line keeps `ev_buffered`=0.
- R12: While a fill is outstanding, `req_ready` is 0 and any presented request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_kind | input | 2 | 0 read, 1 update, 2 merge |
| req_addr | input | 16 | Word address |
| req_op | input | 2 | Reduction opcode |
| req_operand | input | 64 | Update operand |
| req_line | input | 512 | Merge line |
| resp_valid | output | 1 | Response strobe |
| resp_data | output | 64 | Resulting or read word |
| resp_err | output | 1 | Opcode conflict or read of partial-result line |
| fill_req | output | 1 | Line fetch request |
| fill_addr | output | 13 | Line address to fetch |
| fill_valid | input | 1 | Fetched line present |
| fill_data | input | 512 | Fetched line |
| ev_valid | output | 1 | Eviction strobe |
| ev_addr | output | 13 | Evicted line address |
| ev_data | output | 512 | Evicted line contents |
| ev_buffered | output | 1 | Evicted line held partial results |
| ev_op | output | 2 | Opcode of evicted line |

## Verification
A bad fold or a wrong identity fill shows up on `resp_data` in the cycle after the update is accepted. Damage to the other words of a line stays hidden until that line is evicted, and then appears as a wrong word on `ev_data`. A corrupted flag, opcode or recency bit shows only at the next allocation in that set: a wrong `ev_addr`, a wrong `ev_buffered`, a missing eviction pulse or a spurious one. For that reason the bench forces an eviction in every set it touches, and it checks whole lines there.

// File: rtl/ucb_pkg.sv
package ucb_pkg;
  parameter int unsigned UCB_WORD_W = 64;

  typedef enum logic [1:0] {
    RED_ADD = 2'd0,
    RED_AND = 2'd1,
    RED_OR  = 2'd2,
    RED_XOR = 2'd3
  } red_op_e;

  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_UPDATE = 2'd1,
    CMD_MERGE  = 2'd2
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } bank_st_e;

  // Fold one word with another under a reduction opcode.
  function automatic logic [UCB_WORD_W-1:0] red_apply(
    input logic [1:0]            op,
    input logic [UCB_WORD_W-1:0] a,
    input logic [UCB_WORD_W-1:0] b
  );
    case (op)
      RED_ADD: red_apply = a + b;
      RED_AND: red_apply = a & b;
      RED_OR:  red_apply = a | b;
      default: red_apply = a ^ b;
    endcase
  endfunction

  // Neutral element of each reduction.
  function automatic logic [UCB_WORD_W-1:0] red_identity(input logic [1:0] op);
    red_identity = (op == RED_AND) ? {UCB_WORD_W{1'b1}} : '0;
  endfunction
endpackage

// File: rtl/ucb_line_alu.sv
module ucb_line_alu #(
  parameter int WORDS = 8,
  parameter int W     = 64
) (
  input  logic [1:0]         op,
  input  logic [WORDS*W-1:0] base_line,
  input  logic [WORDS*W-1:0] delta_line,
  output logic [WORDS*W-1:0] result_line
);
  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign result_line[g*W +: W] =
      ucb_pkg::red_apply(op, base_line[g*W +: W], delta_line[g*W +: W]);
  end
endmodule

// File: rtl/ucb_tag_match.sv
module ucb_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 11,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [WAY_W-1:0]           lru_way,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim_way
);
  logic [WAYS-1:0] match_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = way_valid[g] && (way_tag[g] == req_tag);
  end

  always_comb begin
    hit     = |match_vec;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    victim_way = lru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/upd_coalesce_bank.sv
module upd_coalesce_bank #(
  parameter int SETS   = 4,
  parameter int WORDS  = 8,
  parameter int ADDR_W = 16,
  parameter int W      = ucb_pkg::UCB_WORD_W,
  parameter int LINE_W = WORDS * W,
  parameter int OFF_W  = $clog2(WORDS),
  parameter int IDX_W  = $clog2(SETS),
  parameter int LADR_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [W-1:0]      req_operand,
  input  logic [LINE_W-1:0] req_line,
  output logic              resp_valid,
  output logic [W-1:0]      resp_data,
  output logic              resp_err,
  output logic              fill_req,
  output logic [LADR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_data,
  output logic              ev_valid,
  output logic [LADR_W-1:0] ev_addr,
  output logic [LINE_W-1:0] ev_data,
  output logic              ev_buffered,
  output logic [1:0]        ev_op
);
  import ucb_pkg::*;

  localparam int WAYS  = 2;
  localparam int WAY_W = 1;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  // Line storage and per-line state
  logic [SETS-1:0][WAYS-1:0]              v_q;
  logic [SETS-1:0][WAYS-1:0]              buf_q;
  logic [SETS-1:0][WAYS-1:0]              dirty_q;
  logic [SETS-1:0][WAYS-1:0][1:0]         lop_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
  logic [SETS-1:0][WAYS-1:0][LINE_W-1:0]  data_q;
  logic [SETS-1:0]                        lru_q;

  bank_st_e           st_q;
  logic [IDX_W-1:0]   pend_idx;
  logic [TAG_W-1:0]   pend_tag;
  logic [OFF_W-1:0]   pend_off;
  logic [WAY_W-1:0]   pend_way;

  function automatic logic [W-1:0] pick_word(
    input logic [LINE_W-1:0] l,
    input logic [OFF_W-1:0]  o
  );
    pick_word = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (o == OFF_W'(w)) pick_word = l[w*W +: W];
    end
  endfunction

  // Request decode
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign off = req_addr[OFF_W-1:0];
  assign idx = req_addr[OFF_W +: IDX_W];
  assign tag = req_addr[ADDR_W-1 -: TAG_W];

  // Named internal events, observed by the checker
  logic             acc_fire;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim_way;
  logic             is_rd, is_upd, is_mrg;
  logic             hit_buf;
  logic             op_conflict;
  logic             read_hit, read_buf, read_miss;
  logic             write_ok;
  logic             alloc;
  logic             evict_fire;
  logic [WAY_W-1:0] tgt_way;

  assign req_ready = (st_q == ST_IDLE);
  assign acc_fire  = req_valid && req_ready;

  ucb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .way_valid  (v_q[idx]),
    .way_tag    (tag_q[idx]),
    .req_tag    (tag),
    .lru_way    (lru_q[idx]),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  assign is_rd       = (req_kind == CMD_READ);
  assign is_upd      = (req_kind == CMD_UPDATE);
  assign is_mrg      = (req_kind == CMD_MERGE);
  assign hit_buf     = hit && buf_q[idx][hit_way];
  assign op_conflict = (is_upd || is_mrg) && hit_buf && (lop_q[idx][hit_way] != req_op);
  assign read_hit    = is_rd && hit && !hit_buf;
  assign read_buf    = is_rd && hit_buf;
  assign read_miss   = is_rd && !hit;
  assign write_ok    = (is_upd || is_mrg) && !op_conflict;
  assign alloc       = (write_ok || read_miss) && !hit;
  assign tgt_way     = hit ? hit_way : victim_way;
  assign evict_fire  = acc_fire && alloc && v_q[idx][victim_way] &&
                       (buf_q[idx][victim_way] || dirty_q[idx][victim_way]);

  // Operand shaping for the reduction unit
  logic [LINE_W-1:0] base_line, delta_line, folded_line;
  logic [W-1:0]      ident_w;

  assign ident_w = red_identity(req_op);

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      base_line[w*W +: W]  = hit ? data_q[idx][hit_way][w*W +: W] : ident_w;
      delta_line[w*W +: W] = is_mrg ? req_line[w*W +: W] :
                             ((off == OFF_W'(w)) ? req_operand : ident_w);
    end
  end

  ucb_line_alu #(.WORDS(WORDS), .W(W)) u_alu (
    .op          (req_op),
    .base_line   (base_line),
    .delta_line  (delta_line),
    .result_line (folded_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q         <= '0;
      buf_q       <= '0;
      dirty_q     <= '0;
      lop_q       <= '0;
      tag_q       <= '0;
      data_q      <= '0;
      lru_q       <= '0;
      st_q        <= ST_IDLE;
      pend_idx    <= '0;
      pend_tag    <= '0;
      pend_off    <= '0;
      pend_way    <= '0;
      resp_valid  <= 1'b0;
      resp_data   <= '0;
      resp_err    <= 1'b0;
      fill_req    <= 1'b0;
      fill_addr   <= '0;
      ev_valid    <= 1'b0;
      ev_addr     <= '0;
      ev_data     <= '0;
      ev_buffered <= 1'b0;
      ev_op       <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_data  <= '0;
      fill_req   <= 1'b0;
      ev_valid   <= 1'b0;

      if (acc_fire) begin
        if (evict_fire) begin
          ev_valid    <= 1'b1;
          ev_addr     <= {tag_q[idx][victim_way], idx};
          ev_data     <= data_q[idx][victim_way];
          ev_buffered <= buf_q[idx][victim_way];
          ev_op       <= lop_q[idx][victim_way];
        end

        if (read_hit) begin
          resp_valid <= 1'b1;
          resp_data  <= pick_word(data_q[idx][hit_way], off);
          lru_q[idx] <= ~hit_way;
        end else if (read_buf || op_conflict) begin
          resp_valid <= 1'b1;
          resp_err   <= 1'b1;
        end else if (read_miss) begin
          st_q                  <= ST_FILL;
          fill_req              <= 1'b1;
          fill_addr             <= {tag, idx};
          pend_idx              <= idx;
          pend_tag              <= tag;
          pend_off              <= off;
          pend_way              <= victim_way;
          v_q[idx][victim_way]  <= 1'b0;
        end else if (write_ok) begin
          data_q[idx][tgt_way] <= folded_line;
          v_q[idx][tgt_way]    <= 1'b1;
          tag_q[idx][tgt_way]  <= tag;
          lru_q[idx]           <= ~tgt_way;
          resp_valid           <= 1'b1;
          resp_data            <= pick_word(folded_line, off);
          if (!hit) begin
            buf_q[idx][tgt_way]   <= 1'b1;
            dirty_q[idx][tgt_way] <= 1'b0;
            lop_q[idx][tgt_way]   <= req_op;
          end else if (!hit_buf) begin
            dirty_q[idx][tgt_way] <= 1'b1;
          end
        end
      end

      if (st_q == ST_FILL && fill_valid) begin
        data_q[pend_idx][pend_way]  <= fill_data;
        v_q[pend_idx][pend_way]     <= 1'b1;
        buf_q[pend_idx][pend_way]   <= 1'b0;
        dirty_q[pend_idx][pend_way] <= 1'b0;
        tag_q[pend_idx][pend_way]   <= pend_tag;
        lru_q[pend_idx]             <= ~pend_way;
        resp_valid                  <= 1'b1;
        resp_data                   <= pick_word(fill_data, pend_off);
        st_q                        <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/ucb_checker.sv
module ucb_checker (
  input logic clk,
  input logic rst_n,
  input logic acc_fire,
  input logic read_miss,
  input logic evict_fire,
  input logic op_conflict,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_err,
  input logic fill_req,
  input logic ev_valid
);
  assert_err_needs_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_valid);

  assert_conflict_answers_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && op_conflict) |=> (resp_valid && resp_err));

  assert_update_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !read_miss) |=> !fill_req);

  assert_resp_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !read_miss) |=> resp_valid);

  assert_fill_from_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> $past(acc_fire && read_miss));

  assert_fill_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !fill_req);

  assert_stall_while_fill_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  assert_evict_from_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(evict_fire));
endmodule

bind upd_coalesce_bank ucb_checker u_ucb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_fire    (acc_fire),
  .read_miss   (read_miss),
  .evict_fire  (evict_fire),
  .op_conflict (op_conflict),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .resp_err    (resp_err),
  .fill_req    (fill_req),
  .ev_valid    (ev_valid)
);

// File: tb/upd_coalesce_bank_bench.sv
module upd_coalesce_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_kind = '0;
  logic [15:0]  req_addr = '0;
  logic [1:0]   req_op = '0;
  logic [63:0]  req_operand = '0;
  logic [511:0] req_line = '0;
  logic         resp_valid;
  logic [63:0]  resp_data;
  logic         resp_err;
  logic         fill_req;
  logic [12:0]  fill_addr;
  logic         fill_valid = 1'b0;
  logic [511:0] fill_data = '0;
  logic         ev_valid;
  logic [12:0]  ev_addr;
  logic [511:0] ev_data;
  logic         ev_buffered;
  logic [1:0]   ev_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  upd_coalesce_bank u_upd_coalesce_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_op(req_op),
    .req_operand(req_operand), .req_line(req_line),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
    .fill_data(fill_data), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_buffered(ev_buffered), .ev_op(ev_op)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic         got_resp, got_err, got_ev, got_ev_buf, got_fill;
  logic [63:0]  got_data;
  logic [12:0]  got_ev_addr, got_fill_addr;
  logic [511:0] got_ev_data;
  logic [1:0]   got_ev_op;

  // Expected-value arithmetic, written from the requirements
  function automatic logic [63:0] bred(input int op, input logic [63:0] x, input logic [63:0] y);
    if (op == 0)      return x + y;
    else if (op == 1) return x & y;
    else if (op == 2) return x | y;
    else              return x ^ y;
  endfunction

  function automatic logic [63:0] bid(input int op);
    return (op == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
  endfunction

  function automatic logic [15:0] mk(input int t, input int s, input int w);
    return 16'((t * 32) + (s * 8) + w);
  endfunction

  function automatic logic [12:0] la(input int t, input int s);
    return 13'((t * 4) + s);
  endfunction

  function automatic logic [63:0] memw(input logic [12:0] a, input int w);
    return (64'h0123_4567_0000_0000 * 64'(w + 1)) ^ 64'(a);
  endfunction

  function automatic logic [511:0] memline(input logic [12:0] a);
    logic [511:0] l;
    for (int w = 0; w < 8; w++) l[w*64 +: 64] = memw(a, w);
    return l;
  endfunction

  function automatic logic [63:0] opa(input int o, input int w);
    return {32'hF0F0_3C3C ^ 32'(o * 7 + w), 32'hFFFF_FFF0 + 32'(w)};
  endfunction

  function automatic logic [63:0] opb(input int o, input int w);
    return {32'(w * 3 + 1), 32'h0000_0033 ^ 32'(o)};
  endfunction

  function automatic logic [63:0] opc(input int o, input int t);
    return 64'h0000_0000_0000_0100 * 64'(t) + 64'(o + 7);
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic expect_resp(input string what, input logic [63:0] data, input logic err);
    chk({what, " resp_valid"}, 64'(got_resp), 64'd1);
    chk({what, " resp_err"}, 64'(got_err), 64'(err));
    chk({what, " resp_data"}, got_data, data);
  endtask

  task automatic expect_ev(input string what, input logic [12:0] a, input logic [511:0] l,
                           input logic b, input int op);
    chk({what, " ev_valid"}, 64'(got_ev), 64'd1);
    chk({what, " ev_addr"}, 64'(got_ev_addr), 64'(a));
    chk({what, " ev_buffered"}, 64'(got_ev_buf), 64'(b));
    if (b) chk({what, " ev_op"}, 64'(got_ev_op), 64'(op));
    for (int w = 0; w < 8; w++)
      chk({what, " ev_data word"}, got_ev_data[w*64 +: 64], l[w*64 +: 64]);
  endtask

  task automatic issue(input logic [1:0] kind, input logic [15:0] addr, input int op,
                       input logic [63:0] opnd, input logic [511:0] line, input bit spur);
    got_fill = 1'b0;
    got_ev   = 1'b0;
    @(negedge clk);
    req_valid   = 1'b1;
    req_kind    = kind;
    req_addr    = addr;
    req_op      = 2'(op);
    req_operand = opnd;
    req_line    = line;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (fill_req) begin
      got_fill      = 1'b1;
      got_fill_addr = fill_addr;
      got_ev        = ev_valid;
      got_ev_addr   = ev_addr;
      got_ev_data   = ev_data;
      got_ev_buf    = ev_buffered;
      got_ev_op     = ev_op;
      fill_valid    = 1'b1;
      fill_data     = memline(fill_addr);
      if (spur) begin
        req_valid   = 1'b1;
        req_kind    = 2'd1;
        req_addr    = mk(20, 3, 0);
        req_op      = 2'd0;
        req_operand = 64'd9;
        chk("R12 req_ready low during fill", 64'(req_ready), 64'd0);
      end
      @(negedge clk);
      fill_valid = 1'b0;
      req_valid  = 1'b0;
    end else begin
      got_ev      = ev_valid;
      got_ev_addr = ev_addr;
      got_ev_data = ev_data;
      got_ev_buf  = ev_buffered;
      got_ev_op   = ev_op;
    end
    got_resp = resp_valid;
    got_err  = resp_err;
    got_data = resp_data;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [511:0] exp_l;
    logic [511:0] mline;
    logic [63:0]  w20;
    logic [63:0]  mw6;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 resp_valid", 64'(resp_valid), 64'd0);
    chk("R1 ev_valid", 64'(ev_valid), 64'd0);
    chk("R1 fill_req", 64'(fill_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after release", 64'(req_ready), 64'd1);

    // Sweep every opcode over every word of one line per set
    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < 8; w++) begin
        issue(2'd1, mk(1, o, w), o, opa(o, w), '0, 1'b0);
        expect_resp("R2 first update", bred(o, bid(o), opa(o, w)), 1'b0);
        chk("R2 no fill on update", 64'(got_fill), 64'd0);
        chk("R8 no eviction into empty set", 64'(got_ev), 64'd0);
      end
      for (int w = 0; w < 8; w++) begin
        issue(2'd1, mk(1, o, w), o, opb(o, w), '0, 1'b0);
        expect_resp("R3 folded update", bred(o, bred(o, bid(o), opa(o, w)), opb(o, w)), 1'b0);
        exp_l[w*64 +: 64] = bred(o, bred(o, bid(o), opa(o, w)), opb(o, w));
      end
      issue(2'd0, mk(1, o, 0), 0, '0, '0, 1'b0);
      expect_resp("R5 read of partial line", 64'd0, 1'b1);
      chk("R5 no fill on partial read", 64'(got_fill), 64'd0);
      issue(2'd1, mk(2, o, 0), o, opc(o, 2), '0, 1'b0);
      expect_resp("R2 second line", bred(o, bid(o), opc(o, 2)), 1'b0);
      chk("R8 invalid way chosen", 64'(got_ev), 64'd0);
      issue(2'd1, mk(3, o, 1), o, opc(o, 3), '0, 1'b0);
      expect_resp("R2 third line", bred(o, bid(o), opc(o, 3)), 1'b0);
      expect_ev("R9 partial line eviction", la(1, o), exp_l, 1'b1, o);
    end

    // R4 opcode conflict on the AND set
    issue(2'd1, mk(2, 1, 0), 3, 64'h55, '0, 1'b0);
    expect_resp("R4 update conflict", 64'd0, 1'b1);
    issue(2'd1, mk(2, 1, 0), 1, bid(1), '0, 1'b0);
    expect_resp("R4 line unchanged", opc(1, 2), 1'b0);
    issue(2'd2, mk(3, 1, 0), 0, '0, {8{64'h1}}, 1'b0);
    expect_resp("R4 merge conflict", 64'd0, 1'b1);
    issue(2'd1, mk(4, 1, 0), 1, 64'h0F, '0, 1'b0);
    expect_resp("R8 alloc in set 1", 64'h0F, 1'b0);
    exp_l = {8{64'hFFFF_FFFF_FFFF_FFFF}};
    exp_l[64 +: 64] = opc(1, 3);
    expect_ev("R8 least recent way evicted", la(3, 1), exp_l, 1'b1, 1);

    // R6 read miss on set 0, with an ignored request while the fill is outstanding
    issue(2'd0, mk(5, 0, 2), 0, '0, '0, 1'b1);
    chk("R6 fill requested", 64'(got_fill), 64'd1);
    chk("R6 fill address", 64'(got_fill_addr), 64'(la(5, 0)));
    expect_resp("R6 fill word", memw(la(5, 0), 2), 1'b0);
    exp_l = '0;
    exp_l[0 +: 64] = opc(0, 2);
    expect_ev("R9 eviction with fill", la(2, 0), exp_l, 1'b1, 0);

    issue(2'd1, mk(20, 3, 0), 0, 64'd5, '0, 1'b0);
    expect_resp("R12 ignored request left no line", 64'd5, 1'b0);

    issue(2'd0, mk(5, 0, 6), 0, '0, '0, 1'b0);
    expect_resp("R5 read hit", memw(la(5, 0), 6), 1'b0);
    chk("R5 no fill on hit", 64'(got_fill), 64'd0);

    mw6 = memw(la(5, 0), 6) ^ 64'hFF;
    issue(2'd1, mk(5, 0, 6), 3, 64'hFF, '0, 1'b0);
    expect_resp("R11 update on data line", mw6, 1'b0);

    issue(2'd1, mk(6, 0, 0), 0, 64'd1, '0, 1'b0);
    exp_l = '0;
    exp_l[64 +: 64] = opc(0, 3);
    expect_ev("R9 evict older partial line", la(3, 0), exp_l, 1'b1, 0);

    issue(2'd1, mk(7, 0, 0), 0, 64'd2, '0, 1'b0);
    exp_l = memline(la(5, 0));
    exp_l[6*64 +: 64] = mw6;
    expect_ev("R10 modified data line", la(5, 0), exp_l, 1'b0, 0);

    // R10 clean data line leaves silently (OR set)
    issue(2'd0, mk(8, 2, 0), 0, '0, '0, 1'b0);
    expect_resp("R6 fill word set 2", memw(la(8, 2), 0), 1'b0);
    exp_l = '0;
    exp_l[0 +: 64] = opc(2, 2);
    expect_ev("R9 evict on read miss", la(2, 2), exp_l, 1'b1, 2);
    issue(2'd1, mk(9, 2, 0), 2, 64'h3, '0, 1'b0);
    expect_resp("R2 alloc set 2", 64'h3, 1'b0);
    chk("R8 older partial line evicted", 64'(got_ev_addr), 64'(la(3, 2)));
    issue(2'd1, mk(10, 2, 0), 2, 64'h4, '0, 1'b0);
    expect_resp("R2 alloc set 2 again", 64'h4, 1'b0);
    chk("R10 clean line silent", 64'(got_ev), 64'd0);

    // R7 merge into a hitting line and merge that allocates (set 3)
    for (int w = 0; w < 8; w++) mline[w*64 +: 64] = 64'h1111_0000_0000_0000 + 64'(w * 13);
    issue(2'd2, mk(20, 3, 4), 0, '0, mline, 1'b0);
    expect_resp("R7 merge hit", mline[4*64 +: 64], 1'b0);
    issue(2'd2, mk(21, 3, 1), 3, '0, ~mline, 1'b0);
    expect_resp("R7 merge miss", ~mline[64 +: 64], 1'b0);
    exp_l = '0;
    exp_l[64 +: 64] = opc(3, 3);
    expect_ev("R9 evict on merge alloc", la(3, 3), exp_l, 1'b1, 3);
    issue(2'd1, mk(21, 3, 5), 3, 64'd0, '0, 1'b0);
    expect_resp("R7 merged line kept", ~mline[5*64 +: 64], 1'b0);
    issue(2'd1, mk(22, 3, 0), 0, 64'd7, '0, 1'b0);
    w20 = 64'd5 + mline[0 +: 64];
    exp_l = mline;
    exp_l[0 +: 64] = w20;
    expect_ev("R7 merged words on eviction", la(20, 3), exp_l, 1'b1, 0);

    report();
  end
endmodule